// File: doc/BRIEF.md
# Three-Wire Serial Select-Window Monitor

This block listens, without driving anything, to the four lines of a half-duplex three-wire serial link: an active-high select, a serial clock, a controller-to-device data line and a device-to-controller data line. All four arrive asynchronously and are first brought into the system clock domain. Every interval during which select is high is treated as one window. The monitor decides what kind of window it is from what it sees. A window whose first serial-clock rise finds the controller data line high is a bit transfer. Any other window is a ready/busy poll of the device.

For a transfer, the monitor reports every bit as a one-cycle record. Each record carries the controller bit sampled on the clock rise, the device bit sampled on the following clock fall, a flag marking the leading start bit, and a running bit index. For a poll, it reports every low-to-high move of the device line as "ready". When select drops, it reports the final level of that line. It also flags two protocol anomalies through a small warning code.

Top module: `mw_monitor`

## Requirements
- R1: All four lines pass through a two-stage synchroniser. A window opens when the synchronised select rises and closes when it falls. No bit, status or warning strobe is high after reset until a window has opened.
- R2: If the serial clock is already high when a window opens, warn_valid pulses with warn_code 1. That high level and the fall that follows it do not start a bit. The first real clock rise does.
- R3: If the controller data line is low at the first clock rise, the window is a poll, warn_valid pulses with warn_code 2, and no bit record is produced in that window.
- R4: In a transfer, each record holds the controller bit seen at the clock rise that began the bit. It also holds the device bit seen at the latest clock fall before the bit ended.
- R5: A bit ends at the next clock rise. The last bit ends when select falls while the clock is low. If select falls while the clock is high, the unfinished bit yields no record.
- R6: The first record of a transfer has is_start_bit = 1 and bit_index 0. Every later record has is_start_bit = 0 and an index one above the record before it.
- R7: From the opening of a window until it is classed as a transfer, each rise of the device line gives status_valid with status_ready = 1 and status_final = 0. A fall of that line gives no report.
- R8: When a window that is not a transfer closes, status_valid pulses with status_final = 1 and status_ready equal to the device-line level at that moment (1 = ready, 0 = busy).
- R9: Once a window is classed as a transfer, changes on the device line produce no status report, and the close of the window produces no final status.
- R10: bit_valid and status_valid are never high in the same cycle. bit_valid never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mw_cs | input | 1 | Select line, active high, asynchronous |
| mw_sk | input | 1 | Serial clock line, asynchronous |
| mw_si | input | 1 | Controller-to-device data line, asynchronous |
| mw_so | input | 1 | Device-to-controller data line, asynchronous |
| bit_valid | output | 1 | One-cycle strobe: a bit record is present |
| bit_si | output | 1 | Controller bit of the record |
| bit_so | output | 1 | Device bit of the record |
| is_start_bit | output | 1 | Record is the leading start bit |
| bit_index | output | IDX_W | Position of the bit within its window, from 0 |
| status_valid | output | 1 | One-cycle strobe: a poll report is present |
| status_ready | output | 1 | 1 = device ready, 0 = device busy |
| status_final | output | 1 | Report is the closing level of the window |
| warn_valid | output | 1 | One-cycle strobe: a protocol warning |
| warn_code | output | 2 | 1 = clock high at open, 2 = no start bit |

## Verification
The hardest cases to reach are those where the decision depends on the clock level at a select edge. One is a window that opens with the clock already high. The other is a transfer cut off while the clock is high, which must drop its last bit. The bench reaches both by ordering its line changes so that the clock is held high across the select rise in one scenario and across the select fall in another. Each level is held for several system cycles so that the synchronised edges arrive in a known order. A clocked poll with the controller line low checks that the classification is made at the first rise. The same scenario checks that the device-line reports still follow.

// File: rtl/mw_pkg.sv
package mw_pkg;

    localparam int LN_CS     = 0;
    localparam int LN_SK     = 1;
    localparam int LN_SI     = 2;
    localparam int LN_SO     = 3;
    localparam int NUM_LINES = 4;

    typedef enum logic [1:0] {
        WIN_IDLE = 2'd0,
        WIN_OPEN = 2'd1,
        WIN_XFER = 2'd2,
        WIN_POLL = 2'd3
    } win_mode_e;

    typedef enum logic [1:0] {
        WARN_NONE     = 2'd0,
        WARN_CLK_HIGH = 2'd1,
        WARN_NO_START = 2'd2
    } warn_e;

    typedef struct packed {
        win_mode_e mode;
        logic      bit_open;
        logic      first;
        logic      cur_si;
        logic      cur_so;
        logic      bit_v;
        logic      out_si;
        logic      out_so;
        logic      out_start;
        logic      stat_v;
        logic      out_ready;
        logic      out_final;
        logic      warn_v;
        warn_e     warn_code;
    } core_state_s;

endpackage

// File: rtl/mw_sync.sv
module mw_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[g] <= '0;
                end else begin
                    stage_q[g] <= stage_d[g];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[LAST];

endmodule

// File: rtl/mw_edge.sv
module mw_edge #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] level_i,
    output logic [WIDTH-1:0] rise_o,
    output logic [WIDTH-1:0] fall_o
);

    logic [WIDTH-1:0] prev_d;
    logic [WIDTH-1:0] prev_q;

    always_comb begin
        prev_d = level_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    generate
        for (genvar g = 0; g < WIDTH; g++) begin : g_line
            assign rise_o[g] = level_i[g] & ~prev_q[g];
            assign fall_o[g] = ~level_i[g] & prev_q[g];
        end
    endgenerate

endmodule

// File: rtl/mw_core.sv
module mw_core
    import mw_pkg::*;
#(
    parameter int IDX_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_lvl,
    input  logic             cs_rise,
    input  logic             cs_fall,
    input  logic             sk_lvl,
    input  logic             sk_rise,
    input  logic             sk_fall,
    input  logic             si_lvl,
    input  logic             so_lvl,
    input  logic             so_rise,
    output logic             bit_valid,
    output logic             bit_si,
    output logic             bit_so,
    output logic             is_start_bit,
    output logic [IDX_W-1:0] bit_index,
    output logic             status_valid,
    output logic             status_ready,
    output logic             status_final,
    output logic             warn_valid,
    output logic [1:0]       warn_code
);

    localparam logic [IDX_W-1:0] IDX_ONE = {{(IDX_W-1){1'b0}}, 1'b1};

    core_state_s       st_d, st_q;
    logic [IDX_W-1:0]  idx_d, idx_q;
    logic [IDX_W-1:0]  oidx_d, oidx_q;
    logic              so_at_close;

    // Device bit for a bit closed by select: a clock fall seen in the same
    // cycle as the select fall still counts as the latest sample.
    assign so_at_close = sk_fall ? so_lvl : st_q.cur_so;

    always_comb begin
        st_d        = st_q;
        idx_d       = idx_q;
        oidx_d      = oidx_q;
        st_d.bit_v  = 1'b0;
        st_d.stat_v = 1'b0;
        st_d.warn_v = 1'b0;

        unique case (st_q.mode)
            WIN_IDLE: begin
                if (cs_rise) begin
                    st_d.mode     = WIN_OPEN;
                    st_d.bit_open = 1'b0;
                    st_d.first    = 1'b1;
                    st_d.cur_si   = 1'b0;
                    st_d.cur_so   = 1'b0;
                    idx_d         = '0;
                    if (sk_lvl) begin
                        st_d.warn_v    = 1'b1;
                        st_d.warn_code = WARN_CLK_HIGH;
                    end
                end
            end

            WIN_OPEN: begin
                if (cs_fall) begin
                    st_d.mode      = WIN_IDLE;
                    st_d.stat_v    = 1'b1;
                    st_d.out_ready = so_lvl;
                    st_d.out_final = 1'b1;
                end else if (sk_rise && si_lvl) begin
                    st_d.mode     = WIN_XFER;
                    st_d.bit_open = 1'b1;
                    st_d.cur_si   = si_lvl;
                end else begin
                    if (sk_rise) begin
                        st_d.mode      = WIN_POLL;
                        st_d.warn_v    = 1'b1;
                        st_d.warn_code = WARN_NO_START;
                    end
                    if (so_rise) begin
                        st_d.stat_v    = 1'b1;
                        st_d.out_ready = 1'b1;
                        st_d.out_final = 1'b0;
                    end
                end
            end

            WIN_XFER: begin
                if (cs_fall) begin
                    st_d.mode     = WIN_IDLE;
                    st_d.bit_open = 1'b0;
                    if (!sk_lvl && st_q.bit_open) begin
                        st_d.bit_v     = 1'b1;
                        st_d.out_si    = st_q.cur_si;
                        st_d.out_so    = so_at_close;
                        st_d.out_start = st_q.first;
                        oidx_d         = idx_q;
                    end
                end else if (sk_rise) begin
                    st_d.bit_v     = 1'b1;
                    st_d.out_si    = st_q.cur_si;
                    st_d.out_so    = st_q.cur_so;
                    st_d.out_start = st_q.first;
                    oidx_d         = idx_q;
                    idx_d          = idx_q + IDX_ONE;
                    st_d.first     = 1'b0;
                    st_d.cur_si    = si_lvl;
                end else if (sk_fall) begin
                    st_d.cur_so = so_lvl;
                end
            end

            WIN_POLL: begin
                if (cs_fall) begin
                    st_d.mode      = WIN_IDLE;
                    st_d.stat_v    = 1'b1;
                    st_d.out_ready = so_lvl;
                    st_d.out_final = 1'b1;
                end else if (so_rise) begin
                    st_d.stat_v    = 1'b1;
                    st_d.out_ready = 1'b1;
                    st_d.out_final = 1'b0;
                end
            end

            default: st_d.mode = WIN_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '{mode: WIN_IDLE, warn_code: WARN_NONE, default: 1'b0};
            idx_q  <= '0;
            oidx_q <= '0;
        end else begin
            st_q   <= st_d;
            idx_q  <= idx_d;
            oidx_q <= oidx_d;
        end
    end

    assign bit_valid    = st_q.bit_v;
    assign bit_si       = st_q.out_si;
    assign bit_so       = st_q.out_so;
    assign is_start_bit = st_q.out_start;
    assign bit_index    = oidx_q;
    assign status_valid = st_q.stat_v;
    assign status_ready = st_q.out_ready;
    assign status_final = st_q.out_final;
    assign warn_valid   = st_q.warn_v;
    assign warn_code    = st_q.warn_code;

    // R10: records and poll reports are exclusive
    a_r10_bit_stat_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(bit_valid && status_valid));

    // R10: a record strobe lasts a single cycle
    a_r10_bit_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |=> !bit_valid);

    // R6: the start record always carries index zero
    a_r6_start_index_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_valid && is_start_bit) |-> (bit_index == '0));

    // R9: records only come out of a window classed as a transfer
    a_r9_bits_only_xfer: assert property (@(posedge clk) disable iff (!rst_n)
        bit_valid |-> $past(st_q.mode) == WIN_XFER);

    // R7: a non-final poll report always means ready
    a_r7_nonfinal_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && !status_final) |-> status_ready);

    // R8: a final report leaves the monitor waiting for the next window
    a_r8_final_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (status_valid && status_final) |-> st_q.mode == WIN_IDLE);

    // R2: clock-high warning appears only as a window opens
    a_r2_clk_warn_open: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_valid && warn_code == WARN_CLK_HIGH) |-> st_q.mode == WIN_OPEN);

    // R3: missing start bit forces a poll window
    a_r3_nostart_poll: assert property (@(posedge clk) disable iff (!rst_n)
        (warn_valid && warn_code == WARN_NO_START) |-> st_q.mode == WIN_POLL);

    // R1: select rise is only acted on while idle, and a window ends on select fall
    a_r1_close_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_fall && st_q.mode != WIN_IDLE) |=> st_q.mode == WIN_IDLE);

endmodule

// File: rtl/mw_monitor.sv
module mw_monitor
    import mw_pkg::*;
#(
    parameter int IDX_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mw_cs,
    input  logic             mw_sk,
    input  logic             mw_si,
    input  logic             mw_so,
    output logic             bit_valid,
    output logic             bit_si,
    output logic             bit_so,
    output logic             is_start_bit,
    output logic [IDX_W-1:0] bit_index,
    output logic             status_valid,
    output logic             status_ready,
    output logic             status_final,
    output logic             warn_valid,
    output logic [1:0]       warn_code
);

    logic [NUM_LINES-1:0] raw_lines;
    logic [NUM_LINES-1:0] sync_lines;
    logic [NUM_LINES-1:0] line_rise;
    logic [NUM_LINES-1:0] line_fall;

    always_comb begin
        raw_lines        = '0;
        raw_lines[LN_CS] = mw_cs;
        raw_lines[LN_SK] = mw_sk;
        raw_lines[LN_SI] = mw_si;
        raw_lines[LN_SO] = mw_so;
    end

    mw_sync #(
        .WIDTH  (NUM_LINES),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_lines),
        .sync_o  (sync_lines)
    );

    mw_edge #(
        .WIDTH (NUM_LINES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (sync_lines),
        .rise_o  (line_rise),
        .fall_o  (line_fall)
    );

    mw_core #(
        .IDX_W (IDX_W)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_lvl       (sync_lines[LN_CS]),
        .cs_rise      (line_rise[LN_CS]),
        .cs_fall      (line_fall[LN_CS]),
        .sk_lvl       (sync_lines[LN_SK]),
        .sk_rise      (line_rise[LN_SK]),
        .sk_fall      (line_fall[LN_SK]),
        .si_lvl       (sync_lines[LN_SI]),
        .so_lvl       (sync_lines[LN_SO]),
        .so_rise      (line_rise[LN_SO]),
        .bit_valid    (bit_valid),
        .bit_si       (bit_si),
        .bit_so       (bit_so),
        .is_start_bit (is_start_bit),
        .bit_index    (bit_index),
        .status_valid (status_valid),
        .status_ready (status_ready),
        .status_final (status_final),
        .warn_valid   (warn_valid),
        .warn_code    (warn_code)
    );

endmodule

// File: tb/mw_monitor_bench.sv
module mw_monitor_bench;

    localparam int HOLD = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sk = 1'b0, si = 1'b0, so = 1'b0;

    logic        bit_valid, bit_si, bit_so, is_start_bit;
    logic [15:0] bit_index;
    logic        status_valid, status_ready, status_final;
    logic        warn_valid;
    logic [1:0]  warn_code;

    always #2.5 clk = ~clk;

    mw_monitor u_mw_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .mw_cs        (cs),
        .mw_sk        (sk),
        .mw_si        (si),
        .mw_so        (so),
        .bit_valid    (bit_valid),
        .bit_si       (bit_si),
        .bit_so       (bit_so),
        .is_start_bit (is_start_bit),
        .bit_index    (bit_index),
        .status_valid (status_valid),
        .status_ready (status_ready),
        .status_final (status_final),
        .warn_valid   (warn_valid),
        .warn_code    (warn_code)
    );

    int checks = 0;
    int fails  = 0;

    // event logs filled by the monitor process
    int          nb = 0, ns = 0, nw = 0, overlap = 0;
    logic        lb_si [32];
    logic        lb_so [32];
    logic        lb_st [32];
    int          lb_ix [32];
    logic        ls_rdy [16];
    logic        ls_fin [16];
    int          lw_code [16];

    always @(negedge clk) begin
        if (rst_n) begin
            if (bit_valid && status_valid) overlap++;
            if (bit_valid && nb < 32) begin
                lb_si[nb] = bit_si; lb_so[nb] = bit_so;
                lb_st[nb] = is_start_bit; lb_ix[nb] = int'(bit_index);
                nb++;
            end
            if (status_valid && ns < 16) begin
                ls_rdy[ns] = status_ready; ls_fin[ns] = status_final;
                ns++;
            end
            if (warn_valid && nw < 16) begin
                lw_code[nw] = int'(warn_code);
                nw++;
            end
        end
    end

    task automatic check_eq(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic hold();
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic clear_logs();
        repeat (3) @(negedge clk);
        nb = 0; ns = 0; nw = 0; overlap = 0;
    endtask

    task automatic drain();
        cs = 1'b0; sk = 1'b0; si = 1'b0; so = 1'b0;
        repeat (10) @(negedge clk);
    endtask

    // one bit: controller data set before the rise, device data after it
    task automatic send_bit(logic si_v, logic so_v);
        si = si_v; hold();
        sk = 1'b1; hold();
        so = so_v; hold();
        sk = 1'b0; hold();
    endtask

    task automatic report_summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    task automatic t_reset();
        // R1: all strobes quiet after reset with idle lines
        repeat (6) @(negedge clk);
        check_eq("R1", "bit_valid after reset", int'(bit_valid), 0);
        check_eq("R1", "status_valid after reset", int'(status_valid), 0);
        check_eq("R1", "warn_valid after reset", int'(warn_valid), 0);
    endtask

    task automatic t_transfer();
        logic exp_si [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
        logic exp_so [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
        clear_logs();
        cs = 1'b1; hold();
        for (int k = 0; k < 4; k++) send_bit(exp_si[k], exp_so[k]);
        cs = 1'b0; hold();
        drain();
        check_eq("R5", "records in clean transfer", nb, 4);
        for (int k = 0; k < 4 && k < nb; k++) begin
            check_eq("R4", $sformatf("si of bit %0d", k), int'(lb_si[k]), int'(exp_si[k]));
            check_eq("R4", $sformatf("so of bit %0d", k), int'(lb_so[k]), int'(exp_so[k]));
            check_eq("R6", $sformatf("start flag of bit %0d", k), int'(lb_st[k]), (k == 0) ? 1 : 0);
            check_eq("R6", $sformatf("index of bit %0d", k), lb_ix[k], k);
        end
        check_eq("R9", "status reports in transfer", ns, 0);
        check_eq("R3", "warnings in transfer", nw, 0);
        check_eq("R10", "bit/status overlap", overlap, 0);
    endtask

    task automatic t_cut_transfer();
        logic exp_si [4] = '{1'b1, 1'b1, 1'b0, 1'b1};
        logic exp_so [4] = '{1'b1, 1'b0, 1'b1, 1'b1};
        clear_logs();
        cs = 1'b1; hold();
        for (int k = 0; k < 3; k++) send_bit(exp_si[k], exp_so[k]);
        si = exp_si[3]; hold();
        sk = 1'b1; hold();
        so = exp_so[3]; hold();
        cs = 1'b0; hold();     // select drops while clock is high
        sk = 1'b0; hold();
        drain();
        check_eq("R5", "records when cut with clock high", nb, 3);
        if (nb >= 3) begin
            check_eq("R4", "si of third bit", int'(lb_si[2]), 0);
            check_eq("R4", "so of third bit", int'(lb_so[2]), 1);
            check_eq("R6", "index of third bit", lb_ix[2], 2);
        end
        check_eq("R9", "no final status in transfer", ns, 0);
    endtask

    task automatic t_clock_high_open();
        clear_logs();
        sk = 1'b1; hold();
        cs = 1'b1; hold();     // window opens with clock high
        sk = 1'b0; hold();
        send_bit(1'b1, 1'b1);
        send_bit(1'b0, 1'b0);
        cs = 1'b0; hold();
        drain();
        check_eq("R2", "warning count", nw, 1);
        if (nw >= 1) check_eq("R2", "warning code", lw_code[0], 1);
        check_eq("R2", "records after clock-high open", nb, 2);
        if (nb >= 2) begin
            check_eq("R2", "first record is start", int'(lb_st[0]), 1);
            check_eq("R2", "first record so", int'(lb_so[0]), 1);
            check_eq("R6", "second index", lb_ix[1], 1);
            check_eq("R4", "second record si", int'(lb_si[1]), 0);
        end
    endtask

    task automatic t_poll_unclocked();
        clear_logs();
        so = 1'b0; cs = 1'b1; hold();
        so = 1'b1; hold();
        so = 1'b0; hold();     // fall: no report
        so = 1'b1; hold();
        cs = 1'b0; hold();
        drain();
        check_eq("R7", "poll report count", ns, 3);
        if (ns >= 3) begin
            check_eq("R7", "first report ready", int'(ls_rdy[0]), 1);
            check_eq("R7", "first report not final", int'(ls_fin[0]), 0);
            check_eq("R7", "second report not final", int'(ls_fin[1]), 0);
            check_eq("R8", "final flag", int'(ls_fin[2]), 1);
            check_eq("R8", "final level ready", int'(ls_rdy[2]), 1);
        end
        check_eq("R3", "no records in poll", nb, 0);
        check_eq("R2", "no warning in unclocked poll", nw, 0);
    endtask

    task automatic t_poll_clocked();
        clear_logs();
        si = 1'b0; so = 1'b0; cs = 1'b1; hold();
        sk = 1'b1; hold();     // first rise with controller line low
        sk = 1'b0; hold();
        send_bit(1'b1, 1'b0);  // later clocks must not yield records
        so = 1'b1; hold();
        so = 1'b0; hold();
        cs = 1'b0; hold();
        drain();
        check_eq("R3", "warning count", nw, 1);
        if (nw >= 1) check_eq("R3", "warning code", lw_code[0], 2);
        check_eq("R3", "no records in clocked poll", nb, 0);
        check_eq("R7", "reports in clocked poll", ns, 2);
        if (ns >= 2) begin
            check_eq("R7", "ready report", int'(ls_rdy[0]), 1);
            check_eq("R8", "final flag busy window", int'(ls_fin[1]), 1);
            check_eq("R8", "final level busy", int'(ls_rdy[1]), 0);
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_transfer();
        t_cut_transfer();
        t_clock_high_open();
        t_poll_unclocked();
        t_poll_clocked();
        report_summary();
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report_summary();
    end

endmodule